// File: doc/BRIEF.md
# NAND Command and Address Latch

This block is the device-side front end of a small-page NAND memory model. It watches an 8-bit I/O bus together with the chip-enable (active low), write-strobe (active low), read-strobe (active low), command-latch and address-latch lines. The strobe lines are sampled in the block's clock domain. A byte present on the bus when the write strobe rises is taken as a command or as an address byte, depending on which latch line is high.

The block decodes commands into an operation mode. It gathers the column and row (page and block) address over successive address cycles. It also keeps a three-way column pointer that selects where a read or a data load starts: the lower main half (bytes 0 to 255), the upper main half (bytes 256 to 511), or the 16-byte spare area (bytes 512 to 527). A page holds 512 main bytes and 16 spare bytes, a block holds 32 pages, and there are 1024 blocks.

When the last address cycle of a read completes, the block pulses a start signal for the internal array read and raises busy. Busy stays high until the array model reports completion. After an ID command followed by a zero address byte, the block serves fixed identification bytes on successive read strobes.

Top module: `nand_cmd_addr_front`

## Requirements
- R1: After reset, op_mode is 0 (idle), col_addr, page_addr and block_addr are 0, and read_start, busy and id_byte are 0. A command byte is latched when we_n rises while ce_n is low, cle is high and ale is low. The op_mode codes are: 00h/01h/50h give 1 (read), 80h gives 2 (data load), 10h gives 3 (program), 60h gives 4 (erase setup), 70h gives 5 (status), 90h gives 6 (ID), and FFh gives 0 (idle).
- R2: An address byte is latched when we_n rises while ce_n is low, ale is high and cle is low. The first cycle after a command is the column byte. The second and third cycles are row bits 7:0 and 15:8. page_addr is row[4:0] and block_addr is row[14:5]. A fourth address cycle changes no output and starts nothing.
- R3: With the lower-half pointer (set by 00h), col_addr equals the column byte.
- R4: With the upper-half pointer (set by 01h), col_addr equals 256 plus the column byte. This pointer lasts for one read only: once that read starts, the pointer returns to the lower half. Until then it still applies to a data-load column.
- R5: With the spare pointer (set by 50h), col_addr equals 512 plus bits 3:0 of the column byte, and bits 7:4 are ignored. This pointer stays in force across reads and data loads until another pointer command arrives.
- R6: On the third address cycle of a read, read_start is high for exactly one clock and busy goes high. Busy stays high until rd_done is seen. Data-load and erase address sequences never pulse read_start.
- R7: While ce_n is high, write-strobe and read-strobe edges are ignored. op_mode, col_addr, page_addr, block_addr and id_byte stay unchanged.
- R8: A write-strobe edge with cle and ale both high latches nothing.
- R9: After 90h and one address byte of 00h, id_byte shows 8'hC5. Each read-strobe rising edge advances to the next identification byte (8'h3A), wrapping back to 8'hC5. If the address byte is not 00h, or after any other command, id_byte is 0.
- R10: After 60h, address cycles carry only the row. The first byte is row[7:0] and the second is row[15:8]. col_addr is left unchanged, and a third byte is ignored.
- R11: FFh sets op_mode to idle, clears busy and returns the pointer to the lower half.
- R12: A command byte outside the nine listed codes leaves op_mode, the pointer and the address cycle count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch line |
| ale | input | 1 | Address latch line |
| we_n | input | 1 | Write strobe, active low, latched on its rising edge |
| re_n | input | 1 | Read strobe, active low, advances the ID byte on its rising edge |
| io_in | input | 8 | I/O bus byte |
| rd_done | input | 1 | Array read completion, clears busy |
| op_mode | output | 3 | Decoded operation mode |
| col_addr | output | 10 | Column start pointer, 0 to 527 |
| page_addr | output | 5 | Page within block |
| block_addr | output | 10 | Block number |
| read_start | output | 1 | One-clock pulse that starts the array read |
| busy | output | 1 | Read in progress |
| id_byte | output | 8 | Current identification byte |

## Verification
The assertions take for granted that every strobe level, latch line and bus byte is held for at least one full clock period, so that each write-strobe rise is seen once and with settled data. They also assume that a latch line changes only while the write strobe is high. The stimulus drives every input on the falling clock edge and keeps each strobe low for exactly one period. It lowers cle and ale only after the rise has been sampled, and it sets up the ce_n-high and double-latch cases with the same timing so that they are excluded only by the block's own gating.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_READ   = 3'd1,
      OP_LOAD   = 3'd2,
      OP_PROG   = 3'd3,
      OP_ERASE  = 3'd4,
      OP_STATUS = 3'd5,
      OP_ID     = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      PTR_LOW   = 2'd0,
      PTR_HIGH  = 2'd1,
      PTR_SPARE = 2'd2
   } ptr_e;

   localparam logic [7:0] CMD_RD_LOW   = 8'h00;
   localparam logic [7:0] CMD_RD_HIGH  = 8'h01;
   localparam logic [7:0] CMD_RD_SPARE = 8'h50;
   localparam logic [7:0] CMD_LOAD     = 8'h80;
   localparam logic [7:0] CMD_PROG     = 8'h10;
   localparam logic [7:0] CMD_ERASE    = 8'h60;
   localparam logic [7:0] CMD_STATUS   = 8'h70;
   localparam logic [7:0] CMD_ID       = 8'h90;
   localparam logic [7:0] CMD_RESET    = 8'hFF;

endpackage

// File: rtl/nfe_strobe.sv
module nfe_strobe #(
   parameter int IN_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic       re_n,
   input  logic [7:0] io_in,
   output logic [7:0] io_s,
   output logic       cmd_stb,
   output logic       addr_stb,
   output logic       rd_stb
);

   logic ce_s, cle_s, ale_s, we_s, re_s;
   logic we_q, re_q;
   logic wr_edge;

   generate
      if (IN_STAGES == 0) begin : g_direct
         assign ce_s  = ce_n;
         assign cle_s = cle;
         assign ale_s = ale;
         assign we_s  = we_n;
         assign re_s  = re_n;
         assign io_s  = io_in;
      end else begin : g_staged
         logic       ce_r, cle_r, ale_r, we_r, re_r;
         logic [7:0] io_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_r  <= 1'b1;
               cle_r <= 1'b0;
               ale_r <= 1'b0;
               we_r  <= 1'b1;
               re_r  <= 1'b1;
               io_r  <= '0;
            end else begin
               ce_r  <= ce_n;
               cle_r <= cle;
               ale_r <= ale;
               we_r  <= we_n;
               re_r  <= re_n;
               io_r  <= io_in;
            end
         end
         assign ce_s  = ce_r;
         assign cle_s = cle_r;
         assign ale_s = ale_r;
         assign we_s  = we_r;
         assign re_s  = re_r;
         assign io_s  = io_r;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1;
         re_q <= 1'b1;
      end else begin
         we_q <= we_s;
         re_q <= re_s;
      end
   end

   assign wr_edge  = we_s && !we_q && !ce_s;
   assign cmd_stb  = wr_edge && cle_s && !ale_s;
   assign addr_stb = wr_edge && ale_s && !cle_s;
   assign rd_stb   = re_s && !re_q && !ce_s;

endmodule

// File: rtl/nfe_cmd_reg.sv
module nfe_cmd_reg
   import nfe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_stb,
   input  logic       read_fire,
   input  logic [7:0] io,
   output op_e        op,
   output ptr_e       ptr,
   output logic       new_cmd,
   output logic       soft_rst
);

   logic known;
   op_e  op_n;
   ptr_e ptr_n;

   always_comb begin
      known = 1'b1;
      op_n  = op;
      ptr_n = ptr;
      case (io)
         CMD_RD_LOW:   begin op_n = OP_READ; ptr_n = PTR_LOW;   end
         CMD_RD_HIGH:  begin op_n = OP_READ; ptr_n = PTR_HIGH;  end
         CMD_RD_SPARE: begin op_n = OP_READ; ptr_n = PTR_SPARE; end
         CMD_LOAD:     op_n = OP_LOAD;
         CMD_PROG:     op_n = OP_PROG;
         CMD_ERASE:    op_n = OP_ERASE;
         CMD_STATUS:   op_n = OP_STATUS;
         CMD_ID:       op_n = OP_ID;
         CMD_RESET:    begin op_n = OP_IDLE; ptr_n = PTR_LOW;   end
         default:      known = 1'b0;
      endcase
   end

   assign new_cmd  = cmd_stb && known;
   assign soft_rst = cmd_stb && (io == CMD_RESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op  <= OP_IDLE;
         ptr <= PTR_LOW;
      end else if (new_cmd) begin
         op  <= op_n;
         ptr <= ptr_n;
      end else if (read_fire && ptr == PTR_HIGH) begin
         ptr <= PTR_LOW;
      end
   end

endmodule

// File: rtl/nfe_addr_latch.sv
module nfe_addr_latch
   import nfe_pkg::*;
#(
   parameter int COL_BITS    = 8,
   parameter int SPARE_BITS  = 4,
   parameter int COL_W       = 10,
   parameter int ROW_BITS    = 15,
   parameter int ROW_CYCLES  = 2,
   parameter int HALF_BYTES  = 256,
   parameter int MAIN_BYTES  = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                new_cmd,
   input  logic                row_only,
   input  logic                addr_stb,
   input  logic [7:0]          io,
   input  ptr_e                ptr,
   output logic [COL_W-1:0]    col_addr,
   output logic [ROW_BITS-1:0] row_addr,
   output logic                col_cyc,
   output logic                last_cyc
);

   localparam int ADDR_CYCLES = 1 + ROW_CYCLES;
   localparam int IDX_W       = $clog2(ADDR_CYCLES + 1);

   logic [IDX_W-1:0]        idx_q;
   logic [IDX_W-1:0]        eff;
   logic                    take;
   logic [COL_W-1:0]        col_next;
   logic [ROW_CYCLES*8-1:0] row_flat;
   logic                    row_unused;

   assign eff      = idx_q + IDX_W'(row_only);
   assign take     = addr_stb && (eff < IDX_W'(ADDR_CYCLES));
   assign col_cyc  = take && (eff == '0);
   assign last_cyc = take && (eff == IDX_W'(ADDR_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (new_cmd) idx_q <= '0;
      else if (take)    idx_q <= idx_q + 1'b1;
   end

   always_comb begin
      case (ptr)
         PTR_HIGH:  col_next = COL_W'(HALF_BYTES) + COL_W'(io[COL_BITS-1:0]);
         PTR_SPARE: col_next = COL_W'(MAIN_BYTES) + COL_W'(io[SPARE_BITS-1:0]);
         default:   col_next = COL_W'(io[COL_BITS-1:0]);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       col_addr <= '0;
      else if (col_cyc) col_addr <= col_next;
   end

   generate
      for (genvar g = 0; g < ROW_CYCLES; g++) begin : g_row
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (take && eff == IDX_W'(g + 1))
               byte_q <= io;
         end
         assign row_flat[g*8 +: 8] = byte_q;
      end
   endgenerate

   assign row_addr   = row_flat[ROW_BITS-1:0];
   assign row_unused = ^row_flat;

endmodule

// File: rtl/nfe_id_unit.sv
module nfe_id_unit #(
   parameter int                   ID_BYTES = 2,
   parameter logic [ID_BYTES*8-1:0] ID_CODE = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       new_cmd,
   input  logic       is_id,
   input  logic       col_cyc,
   input  logic       rd_stb,
   input  logic [7:0] io,
   output logic [7:0] id_byte
);

   localparam int IW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

   logic [7:0]    tbl [ID_BYTES];
   logic          armed;
   logic [IW-1:0] idx;

   generate
      for (genvar g = 0; g < ID_BYTES; g++) begin : g_tbl
         assign tbl[g] = ID_CODE[g*8 +: 8];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         idx   <= '0;
      end else if (new_cmd) begin
         armed <= 1'b0;
         idx   <= '0;
      end else if (col_cyc && is_id) begin
         armed <= (io == 8'h00);
         idx   <= '0;
      end else if (rd_stb && armed) begin
         idx <= (idx == IW'(ID_BYTES - 1)) ? '0 : idx + 1'b1;
      end
   end

   assign id_byte = armed ? tbl[idx] : 8'h00;

endmodule

// File: rtl/nand_cmd_addr_front.sv
module nand_cmd_addr_front
   import nfe_pkg::*;
#(
   parameter int                    MAIN_BYTES  = 512,
   parameter int                    SPARE_BYTES = 16,
   parameter int                    PAGE_BITS   = 5,
   parameter int                    BLOCK_BITS  = 10,
   parameter int                    ID_BYTES    = 2,
   parameter logic [ID_BYTES*8-1:0] ID_CODE     = 16'h3AC5,
   parameter int                    IN_STAGES   = 0,
   localparam int                   COL_W       = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce_n,
   input  logic                  cle,
   input  logic                  ale,
   input  logic                  we_n,
   input  logic                  re_n,
   input  logic [7:0]            io_in,
   input  logic                  rd_done,
   output logic [2:0]            op_mode,
   output logic [COL_W-1:0]      col_addr,
   output logic [PAGE_BITS-1:0]  page_addr,
   output logic [BLOCK_BITS-1:0] block_addr,
   output logic                  read_start,
   output logic                  busy,
   output logic [7:0]            id_byte
);

   localparam int HALF_BYTES = MAIN_BYTES / 2;
   localparam int COL_BITS   = $clog2(HALF_BYTES);
   localparam int SPARE_BITS = $clog2(SPARE_BYTES);
   localparam int ROW_BITS   = PAGE_BITS + BLOCK_BITS;
   localparam int ROW_CYCLES = (ROW_BITS + 7) / 8;

   generate
      if (COL_BITS > 8 || (1 << COL_BITS) != HALF_BYTES)
         $error("main area must be twice a power of two that one bus byte can index");
      if ((1 << SPARE_BITS) != SPARE_BYTES || SPARE_BYTES > HALF_BYTES)
         $error("spare area must be a power of two no larger than half the main area");
      if (ID_BYTES < 1)
         $error("at least one identification byte is needed");
      if (IN_STAGES != 0 && IN_STAGES != 1)
         $error("input staging must be 0 or 1");
   endgenerate

   logic [7:0]          io_s;
   logic                cmd_stb, addr_stb, rd_stb;
   op_e                 op;
   ptr_e                ptr;
   logic                new_cmd, soft_rst;
   logic                col_cyc, last_cyc;
   logic                read_fire;
   logic [ROW_BITS-1:0] row_addr;

   nfe_strobe #(.IN_STAGES(IN_STAGES)) i_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .cle      (cle),
      .ale      (ale),
      .we_n     (we_n),
      .re_n     (re_n),
      .io_in    (io_in),
      .io_s     (io_s),
      .cmd_stb  (cmd_stb),
      .addr_stb (addr_stb),
      .rd_stb   (rd_stb)
   );

   nfe_cmd_reg i_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_stb   (cmd_stb),
      .read_fire (read_fire),
      .io        (io_s),
      .op        (op),
      .ptr       (ptr),
      .new_cmd   (new_cmd),
      .soft_rst  (soft_rst)
   );

   nfe_addr_latch #(
      .COL_BITS   (COL_BITS),
      .SPARE_BITS (SPARE_BITS),
      .COL_W      (COL_W),
      .ROW_BITS   (ROW_BITS),
      .ROW_CYCLES (ROW_CYCLES),
      .HALF_BYTES (HALF_BYTES),
      .MAIN_BYTES (MAIN_BYTES)
   ) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .new_cmd  (new_cmd),
      .row_only (op == OP_ERASE),
      .addr_stb (addr_stb),
      .io       (io_s),
      .ptr      (ptr),
      .col_addr (col_addr),
      .row_addr (row_addr),
      .col_cyc  (col_cyc),
      .last_cyc (last_cyc)
   );

   nfe_id_unit #(.ID_BYTES(ID_BYTES), .ID_CODE(ID_CODE)) i_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .new_cmd (new_cmd),
      .is_id   (op == OP_ID),
      .col_cyc (col_cyc),
      .rd_stb  (rd_stb),
      .io      (io_s),
      .id_byte (id_byte)
   );

   assign read_fire = last_cyc && (op == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         read_start <= 1'b0;
         busy       <= 1'b0;
      end else begin
         read_start <= read_fire;
         if (soft_rst)       busy <= 1'b0;
         else if (read_fire) busy <= 1'b1;
         else if (rd_done)   busy <= 1'b0;
      end
   end

   assign op_mode    = op;
   assign page_addr  = row_addr[PAGE_BITS-1:0];
   assign block_addr = row_addr[ROW_BITS-1:PAGE_BITS];

endmodule

// File: rtl/nfe_checker.sv
module nfe_checker #(
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int COL_W       = 10,
   parameter int PAGE_BITS   = 5,
   parameter int BLOCK_BITS  = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ce_n,
   input logic                  cle,
   input logic                  ale,
   input logic [2:0]            op_mode,
   input logic [COL_W-1:0]      col_addr,
   input logic [PAGE_BITS-1:0]  page_addr,
   input logic [BLOCK_BITS-1:0] block_addr,
   input logic                  read_start,
   input logic                  busy
);

   AST_CE_HIGH_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> $stable(op_mode) && $stable(col_addr) && $stable(page_addr) && $stable(block_addr)); // R7

   AST_DOUBLE_LATCH_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (cle && ale) |=> $stable(op_mode) && $stable(col_addr) && $stable(page_addr) && $stable(block_addr)); // R8

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      read_start |=> !read_start); // R6

   AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      read_start |-> busy); // R6

   AST_START_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      read_start |-> (op_mode == 3'd1)); // R6

   AST_COL_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      col_addr < COL_W'(MAIN_BYTES + SPARE_BYTES)); // R5

endmodule

bind nand_cmd_addr_front nfe_checker #(
   .MAIN_BYTES  (MAIN_BYTES),
   .SPARE_BYTES (SPARE_BYTES),
   .COL_W       (COL_W),
   .PAGE_BITS   (PAGE_BITS),
   .BLOCK_BITS  (BLOCK_BITS)
) i_nfe_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .cle        (cle),
   .ale        (ale),
   .op_mode    (op_mode),
   .col_addr   (col_addr),
   .page_addr  (page_addr),
   .block_addr (block_addr),
   .read_start (read_start),
   .busy       (busy)
);

// File: tb/test_nand_cmd_addr_front.sv
`timescale 1ns/1ps
module test_nand_cmd_addr_front;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b0;
   logic       cle = 1'b0;
   logic       ale = 1'b0;
   logic       we_n = 1'b1;
   logic       re_n = 1'b1;
   logic [7:0] io_in = 8'h00;
   logic       rd_done = 1'b0;
   logic [2:0] op_mode;
   logic [9:0] col_addr;
   logic [4:0] page_addr;
   logic [9:0] block_addr;
   logic       read_start;
   logic       busy;
   logic [7:0] id_byte;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   nand_cmd_addr_front i_nand_cmd_addr_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .cle        (cle),
      .ale        (ale),
      .we_n       (we_n),
      .re_n       (re_n),
      .io_in      (io_in),
      .rd_done    (rd_done),
      .op_mode    (op_mode),
      .col_addr   (col_addr),
      .page_addr  (page_addr),
      .block_addr (block_addr),
      .read_start (read_start),
      .busy       (busy),
      .id_byte    (id_byte)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic strobe(input logic c, input logic a, input logic [7:0] b, input logic ce_hi);
      @(negedge clk);
      ce_n = ce_hi; cle = c; ale = a; io_in = b; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b);
      strobe(1'b1, 1'b0, b, 1'b0);
   endtask

   task automatic adr(input logic [7:0] b);
      strobe(1'b0, 1'b1, b, 1'b0);
   endtask

   task automatic re_pulse();
      @(negedge clk); re_n = 1'b0;
      @(negedge clk); re_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_read();
      @(negedge clk); rd_done = 1'b1;
      @(negedge clk); rd_done = 1'b0;
   endtask

   function automatic bit is_known(input logic [7:0] b);
      return b == 8'h00 || b == 8'h01 || b == 8'h50 || b == 8'h80 || b == 8'h10 ||
             b == 8'h60 || b == 8'h70 || b == 8'h90 || b == 8'hFF;
   endfunction

   task automatic read_sweep(input logic [7:0] code, input string tag, input int kind);
      for (int b = 0; b < 256; b++) begin
         logic [7:0]  r1, r2;
         logic [15:0] row;
         int          ecol;
         r1  = 8'(b * 37 + 11);
         r2  = 8'(b) ^ 8'h5A;
         row = {r2, r1};
         if (kind == 0)      ecol = b;
         else if (kind == 1) ecol = 256 + b;
         else                ecol = 512 + (b % 16);
         cmd(code); adr(8'(b)); adr(r1); adr(r2);
         chk({tag, " column"}, 32'(col_addr), 32'(ecol));
         chk("R2 page", 32'(page_addr), 32'(row[4:0]));
         chk("R2 block", 32'(block_addr), 32'(row[14:5]));
         chk("R6 start", 32'(read_start), 32'd1);
         finish_read();
         chk("R6 busy cleared", 32'(busy), 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [9:0] held_col;
      logic [4:0] held_page;
      logic [9:0] held_block;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 op reset", 32'(op_mode), 32'd0);
      chk("R1 col reset", 32'(col_addr), 32'd0);
      chk("R1 page reset", 32'(page_addr), 32'd0);
      chk("R1 block reset", 32'(block_addr), 32'd0);
      chk("R1 start reset", 32'(read_start), 32'd0);
      chk("R1 busy reset", 32'(busy), 32'd0);
      chk("R1 id reset", 32'(id_byte), 32'd0);

      // R1 command decode
      cmd(8'h80); chk("R1 op 80h", 32'(op_mode), 32'd2);
      cmd(8'h10); chk("R1 op 10h", 32'(op_mode), 32'd3);
      cmd(8'h60); chk("R1 op 60h", 32'(op_mode), 32'd4);
      cmd(8'h70); chk("R1 op 70h", 32'(op_mode), 32'd5);
      cmd(8'h90); chk("R1 op 90h", 32'(op_mode), 32'd6);
      cmd(8'h00); chk("R1 op 00h", 32'(op_mode), 32'd1);
      cmd(8'hFF); chk("R1 op FFh", 32'(op_mode), 32'd0);
      cmd(8'h01); chk("R1 op 01h", 32'(op_mode), 32'd1);
      cmd(8'h50); chk("R1 op 50h", 32'(op_mode), 32'd1);
      cmd(8'hFF);

      // R12 unknown commands ignored
      for (int b = 0; b < 256; b++) begin
         if (!is_known(8'(b))) begin
            cmd(8'h70);
            cmd(8'(b));
            chk("R12 unknown op", 32'(op_mode), 32'd5);
         end
      end
      cmd(8'h01); cmd(8'h3C); adr(8'h21);
      chk("R12 pointer kept", 32'(col_addr), 32'd256 + 32'h21);

      // R3, R4, R5 pointer sweeps
      read_sweep(8'h00, "R3", 0);
      read_sweep(8'h01, "R4", 1);
      read_sweep(8'h50, "R5", 2);

      // R2 fourth cycle ignored
      cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'h56);
      finish_read();
      held_col = col_addr; held_page = page_addr; held_block = block_addr;
      adr(8'hAB);
      chk("R2 4th start", 32'(read_start), 32'd0);
      chk("R2 4th col", 32'(col_addr), 32'(held_col));
      chk("R2 4th page", 32'(page_addr), 32'(held_page));
      chk("R2 4th block", 32'(block_addr), 32'(held_block));
      chk("R2 4th busy", 32'(busy), 32'd0);

      // R6 pulse width, busy hold, no start on data load
      cmd(8'h00); adr(8'h05); adr(8'h06); adr(8'h07);
      chk("R6 start high", 32'(read_start), 32'd1);
      @(negedge clk);
      chk("R6 start one cycle", 32'(read_start), 32'd0);
      repeat (4) @(negedge clk);
      chk("R6 busy held", 32'(busy), 32'd1);
      finish_read();
      chk("R6 busy released", 32'(busy), 32'd0);
      cmd(8'h80); adr(8'h09); adr(8'h0A); adr(8'h0B);
      chk("R6 load no start", 32'(read_start), 32'd0);
      chk("R6 load no busy", 32'(busy), 32'd0);

      // R4 one-shot pointer
      cmd(8'h01); adr(8'h10); adr(8'h00); adr(8'h00);
      finish_read();
      cmd(8'h80); adr(8'h22);
      chk("R4 fallback after read", 32'(col_addr), 32'h22);
      cmd(8'h01); cmd(8'h80); adr(8'h22);
      chk("R4 held before read", 32'(col_addr), 32'd256 + 32'h22);

      // R5 persistent spare pointer
      cmd(8'h50); adr(8'hF3); adr(8'h00); adr(8'h00);
      finish_read();
      cmd(8'h80); adr(8'h37);
      chk("R5 spare after read", 32'(col_addr), 32'd512 + 32'd7);
      cmd(8'h80); adr(8'hEC);
      chk("R5 spare kept", 32'(col_addr), 32'd512 + 32'd12);

      // R11 soft reset
      cmd(8'h50); adr(8'h01); adr(8'h02); adr(8'h03);
      chk("R11 busy before", 32'(busy), 32'd1);
      cmd(8'hFF);
      chk("R11 busy cleared", 32'(busy), 32'd0);
      chk("R11 op idle", 32'(op_mode), 32'd0);
      cmd(8'h80); adr(8'h44);
      chk("R11 pointer low", 32'(col_addr), 32'h44);

      // R7 chip enable high
      cmd(8'h70);
      held_col = col_addr;
      strobe(1'b1, 1'b0, 8'h90, 1'b1);
      chk("R7 cmd ignored", 32'(op_mode), 32'd5);
      strobe(1'b0, 1'b1, 8'h99, 1'b1);
      chk("R7 addr ignored", 32'(col_addr), 32'(held_col));
      cmd(8'h90); adr(8'h00);
      @(negedge clk); ce_n = 1'b1; re_n = 1'b0;
      @(negedge clk); re_n = 1'b1;
      @(negedge clk); ce_n = 1'b0;
      chk("R7 read strobe ignored", 32'(id_byte), 32'hC5);

      // R8 both latch lines
      cmd(8'h70);
      held_col = col_addr; held_page = page_addr;
      strobe(1'b1, 1'b1, 8'h90, 1'b0);
      chk("R8 op unchanged", 32'(op_mode), 32'd5);
      chk("R8 col unchanged", 32'(col_addr), 32'(held_col));
      chk("R8 page unchanged", 32'(page_addr), 32'(held_page));

      // R9 identification
      cmd(8'h90); adr(8'h00);
      chk("R9 first id", 32'(id_byte), 32'hC5);
      re_pulse();
      chk("R9 second id", 32'(id_byte), 32'h3A);
      re_pulse();
      chk("R9 wrap id", 32'(id_byte), 32'hC5);
      cmd(8'h70);
      chk("R9 cleared by cmd", 32'(id_byte), 32'h00);
      cmd(8'h90); adr(8'h01);
      chk("R9 nonzero address", 32'(id_byte), 32'h00);

      // R10 erase row-only addressing
      cmd(8'h80); adr(8'h2D);
      held_col = col_addr;
      cmd(8'h60); adr(8'hC7); adr(8'h6E);
      chk("R10 page", 32'(page_addr), 32'h07);
      chk("R10 block", 32'(block_addr), 32'(10'({8'h6E, 8'hC7} >> 5)));
      chk("R10 col kept", 32'(col_addr), 32'(held_col));
      chk("R10 no start", 32'(read_start), 32'd0);
      adr(8'hFF);
      chk("R10 third ignored", 32'(page_addr), 32'h07);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule